// File: doc/BRIEF.md
# Dual-Buffer Message Capture Engine

This block takes a stream of 32-bit samples grouped into messages and turns it into address/data words for a memory-write FIFO. A message opens with a start strobe and closes with a stop strobe. The sample beats between the two are the message body. Two buffers take turns receiving messages. Each buffer has a programmable base address. All record slots share one slot size in words and one slot count per buffer. Every message begins at the next record slot, so slots stay aligned when a message is short or cut off.

When a buffer has taken its full count of messages, the block pulses a full indication for that buffer and moves to the other buffer. If timestamp insertion is on, the word of a free-running arrival timer is written ahead of each message's first sample. Each buffer counts its completed messages. Three sticky status flags record trouble: overrun, a sample lost to a full FIFO, and a message longer than its slot. Software clears each flag by writing a one to its clear bit.

Top module: `msg_capture`

## Requirements
- R1: After reset, wf_push, buf_full, flags, done_cnt0, done_cnt1 and cur_buf are all zero, and buffer 0 is the active buffer.
- R2: An accepted sample is pushed one cycle later. Its address is base[cur] + 4*(slot*rec_words + offset). Slot is the record index within the active buffer. Offset counts the words already written in the message. The sample's data is carried unchanged.
- R3: When ts_insert is 1, an accepted start pushes the ts_now value seen at that start at offset 0 of the slot. The message's samples then begin at offset 1.
- R4: ts_now advances by exactly one every 8 clock cycles.
- R5: A sample that arrives after rec_words words of the message have been used is not pushed. It sets flags bit 2 (slot overflow).
- R6: A word that would be pushed while wf_full is 1 is not pushed and sets flags bit 1 (bandwidth error). The next word is still placed at its own offset.
- R7: Every accepted stop increments the completed-message counter of the active buffer (done_cnt0 or done_cnt1).
- R8: Writing a buffer's base address clears that buffer's counter to zero and leaves the other counter unchanged.
- R9: The stop that completes rec_count messages in a buffer pulses buf_full for that buffer for one cycle, with bit 0 for buffer 0. It also switches cur_buf to the other buffer, whose next message goes to slot 0.
- R10: When ovr_enable is 1, a start that arrives while the active buffer is full and unacknowledged sets flags bit 0 (overrun). That message is discarded, and capture stalls: starts, samples and stops are all ignored.
- R11: A full_ack bit clears that buffer's full state. During a stall, any ack resumes capture. Capture continues in the active buffer if that buffer was acknowledged, and otherwise in the other buffer.
- R12: Each flags bit stays set until a 1 is written to the matching flag_clear bit. A clear touches only its own bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| base0_wdata | input | AW | New base address for buffer 0 |
| base0_we | input | 1 | Write strobe for buffer 0 base |
| base1_wdata | input | AW | New base address for buffer 1 |
| base1_we | input | 1 | Write strobe for buffer 1 base |
| rec_words | input | RW | Slot size in 32-bit words |
| rec_count | input | NW | Slots per buffer |
| ts_insert | input | 1 | Prefix each message with a timestamp word |
| ovr_enable | input | 1 | Enable overrun detection and stall |
| evt_start | input | 1 | Message start strobe |
| evt_stop | input | 1 | Message stop strobe |
| smp_valid | input | 1 | Sample beat valid |
| smp_data | input | DW | Sample data |
| full_ack | input | 2 | Buffer-full acknowledge, one bit per buffer |
| flag_clear | input | 3 | Write-one-to-clear for flags |
| wf_full | input | 1 | Memory-write FIFO cannot accept a word |
| wf_push | output | 1 | Push one word into the FIFO |
| wf_addr | output | AW | Byte address of the pushed word |
| wf_data | output | DW | Pushed word |
| buf_full | output | 2 | One-cycle buffer-full pulse per buffer |
| done_cnt0 | output | CW | Completed messages in buffer 0 |
| done_cnt1 | output | CW | Completed messages in buffer 1 |
| flags | output | 3 | Sticky flags: bit 0 overrun, bit 1 bandwidth error, bit 2 overflow |
| cur_buf | output | 1 | Active buffer |
| ts_now | output | TSW | Arrival timer value |

## Verification
A wrong word offset or slot index appears as a wrong wf_addr on the very next push. The bench compares every push with an address it computes from base, slot and offset. A record index that fails to wrap or advance surfaces only at the next message start, as a slot off by one, or at the completing stop, as a missing or late buf_full pulse together with cur_buf not switching. A stall state that does not clear appears as missing pushes after an acknowledge. Stale full state appears as a false overrun flag at the next start in that buffer.

// File: rtl/msg_cap_pkg.sv
package msg_cap_pkg;
  localparam int NFLAG   = 3;
  localparam int FLG_OVR = 0;
  localparam int FLG_MBE = 1;
  localparam int FLG_OFL = 2;
  localparam int BYTE_SHIFT = 2;  // 4 bytes per word

  // word index inside a buffer: slot number times slot size plus offset
  function automatic logic [31:0] word_index(input logic [31:0] slot,
                                             input logic [31:0] words,
                                             input logic [31:0] off);
    return slot * words + off;
  endfunction
endpackage

// File: rtl/msg_ts_counter.sv
module msg_ts_counter #(
  parameter int TSW = 32,
  parameter int DIV = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  output logic [TSW-1:0] ts
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] presc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      presc <= '0;
      ts    <= '0;
    end else if (presc == LAST) begin
      presc <= '0;
      ts    <= ts + 1'b1;
    end else begin
      presc <= presc + 1'b1;
    end
  end
endmodule

// File: rtl/msg_sticky_flags.sv
module msg_sticky_flags #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] q
);
  for (genvar k = 0; k < N; k++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n)      q[k] <= 1'b0;
      else if (set[k]) q[k] <= 1'b1;   // a new event wins over a clear
      else if (clr[k]) q[k] <= 1'b0;
    end
  end
endmodule

// File: rtl/msg_done_counter.sv
module msg_done_counter #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          inc,
  output logic [CW-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)   q <= '0;
    else if (clr) q <= '0;
    else if (inc) q <= q + 1'b1;
  end
endmodule

// File: rtl/msg_capture.sv
module msg_capture #(
  parameter int AW     = 32,
  parameter int DW     = 32,
  parameter int RW     = 8,
  parameter int NW     = 8,
  parameter int CW     = 16,
  parameter int TSW    = 32,
  parameter int TS_DIV = 8
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [AW-1:0]                   base0_wdata,
  input  logic                            base0_we,
  input  logic [AW-1:0]                   base1_wdata,
  input  logic                            base1_we,
  input  logic [RW-1:0]                   rec_words,
  input  logic [NW-1:0]                   rec_count,
  input  logic                            ts_insert,
  input  logic                            ovr_enable,
  input  logic                            evt_start,
  input  logic                            evt_stop,
  input  logic                            smp_valid,
  input  logic [DW-1:0]                   smp_data,
  input  logic [1:0]                      full_ack,
  input  logic [msg_cap_pkg::NFLAG-1:0]   flag_clear,
  input  logic                            wf_full,
  output logic                            wf_push,
  output logic [AW-1:0]                   wf_addr,
  output logic [DW-1:0]                   wf_data,
  output logic [1:0]                      buf_full,
  output logic [CW-1:0]                   done_cnt0,
  output logic [CW-1:0]                   done_cnt1,
  output logic [msg_cap_pkg::NFLAG-1:0]   flags,
  output logic                            cur_buf,
  output logic [TSW-1:0]                  ts_now
);
  import msg_cap_pkg::*;

  function automatic logic [AW-1:0] slot_addr(input logic [AW-1:0] base,
                                               input logic [NW-1:0] slot,
                                               input logic [RW-1:0] words,
                                               input logic [RW:0]   off);
    logic [31:0] w;
    w = word_index(32'(slot), 32'(words), 32'(off));
    return base + AW'(w << BYTE_SHIFT);
  endfunction

  // architectural state
  logic [1:0][AW-1:0] base_q;
  logic               cur;
  logic [NW-1:0]      rec_idx;
  logic [RW:0]        word_off;
  logic               in_msg;
  logic               stalled;
  logic [1:0]         pend;

  // named internal events (observed by the checker)
  logic accept_start, ev_ovr, msg_begin, ts_word;
  logic stop_ok, smp_ok, smp_fits, ev_ofl, want_write, ev_mbe, do_push;
  logic last_slot, ev_switch;
  logic [1:0] base_we;
  logic [RW:0] wr_off;

  assign base_we      = {base1_we, base0_we};
  assign accept_start = evt_start && !stalled && !in_msg;
  assign ev_ovr       = accept_start && ovr_enable && pend[cur];
  assign msg_begin    = accept_start && !ev_ovr;
  assign ts_word      = msg_begin && ts_insert;
  assign stop_ok      = evt_stop && !evt_start && !stalled && in_msg;
  assign smp_ok       = smp_valid && !evt_start && !evt_stop && !stalled && in_msg;
  assign smp_fits     = word_off < {1'b0, rec_words};
  assign ev_ofl       = smp_ok && !smp_fits;
  assign want_write   = ts_word || (smp_ok && smp_fits);
  assign ev_mbe       = want_write && wf_full;
  assign do_push      = want_write && !wf_full;
  assign last_slot    = ({1'b0, rec_idx} + 1'b1) >= {1'b0, rec_count};
  assign ev_switch    = stop_ok && last_slot;
  assign wr_off       = ts_word ? '0 : word_off;

  msg_ts_counter #(.TSW(TSW), .DIV(TS_DIV)) u_ts (
    .clk(clk), .rst_n(rst_n), .ts(ts_now)
  );

  logic [NFLAG-1:0] flag_set;
  always_comb begin
    flag_set          = '0;
    flag_set[FLG_OVR] = ev_ovr;
    flag_set[FLG_MBE] = ev_mbe;
    flag_set[FLG_OFL] = ev_ofl;
  end

  msg_sticky_flags #(.N(NFLAG)) u_flags (
    .clk(clk), .rst_n(rst_n), .set(flag_set), .clr(flag_clear), .q(flags)
  );

  logic [1:0][CW-1:0] cnt;
  for (genvar i = 0; i < 2; i++) begin : g_cnt
    msg_done_counter #(.CW(CW)) u_cnt (
      .clk(clk), .rst_n(rst_n), .clr(base_we[i]),
      .inc(stop_ok && (cur == 1'(i))), .q(cnt[i])
    );
    always_ff @(posedge clk) begin
      if (!rst_n)                           pend[i] <= 1'b0;
      else if (ev_switch && cur == 1'(i))   pend[i] <= 1'b1;
      else if (full_ack[i])                 pend[i] <= 1'b0;
    end
  end
  assign done_cnt0 = cnt[0];
  assign done_cnt1 = cnt[1];

  always_ff @(posedge clk) begin
    if (!rst_n) base_q <= '0;
    else begin
      if (base0_we) base_q[0] <= base0_wdata;
      if (base1_we) base_q[1] <= base1_wdata;
    end
  end

  // sequencing
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur      <= 1'b0;
      rec_idx  <= '0;
      word_off <= '0;
      in_msg   <= 1'b0;
      stalled  <= 1'b0;
    end else if (ev_ovr) begin
      stalled <= 1'b1;
    end else if (stalled) begin
      if (|full_ack) begin
        stalled <= 1'b0;
        cur     <= full_ack[cur] ? cur : ~cur;
        rec_idx <= '0;
      end
    end else if (msg_begin) begin
      in_msg   <= 1'b1;
      word_off <= (RW+1)'(ts_insert);
    end else if (stop_ok) begin
      in_msg <= 1'b0;
      if (last_slot) begin
        cur     <= ~cur;
        rec_idx <= '0;
      end else begin
        rec_idx <= rec_idx + 1'b1;
      end
    end else if (smp_ok && smp_fits) begin
      word_off <= word_off + 1'b1;   // advances even when the push is lost
    end
  end

  // output register stage
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wf_push  <= 1'b0;
      wf_addr  <= '0;
      wf_data  <= '0;
      buf_full <= '0;
    end else begin
      wf_push  <= do_push;
      buf_full <= {ev_switch && cur, ev_switch && !cur};
      if (do_push) begin
        wf_addr <= slot_addr(base_q[cur], rec_idx, rec_words, wr_off);
        wf_data <= ts_word ? DW'(ts_now) : smp_data;
      end
    end
  end

  assign cur_buf = cur;
endmodule

// File: rtl/msg_capture_chk.sv
module msg_capture_chk #(
  parameter int CW  = 16,
  parameter int TSW = 32
) (
  input logic           clk,
  input logic           rst_n,
  input logic           ev_ovr,
  input logic           ev_mbe,
  input logic           ev_ofl,
  input logic           base0_we,
  input logic           base1_we,
  input logic [2:0]     flag_clear,
  input logic           wf_push,
  input logic [1:0]     buf_full,
  input logic [2:0]     flags,
  input logic           cur_buf,
  input logic [CW-1:0]  done_cnt0,
  input logic [CW-1:0]  done_cnt1,
  input logic [TSW-1:0] ts_now
);
  a_r4_ts_step: assert property (@(posedge clk) disable iff (!rst_n)
    (ts_now == $past(ts_now)) || (ts_now == $past(ts_now) + 1'b1));

  a_r5_ofl_flag: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ofl |=> (flags[2] && !wf_push));

  a_r6_mbe_flag: assert property (@(posedge clk) disable iff (!rst_n)
    ev_mbe |=> flags[1]);

  a_r6_mbe_no_push: assert property (@(posedge clk) disable iff (!rst_n)
    ev_mbe |=> !wf_push);

  a_r8_clr0: assert property (@(posedge clk) disable iff (!rst_n)
    base0_we |=> (done_cnt0 == '0));

  a_r8_clr1: assert property (@(posedge clk) disable iff (!rst_n)
    base1_we |=> (done_cnt1 == '0));

  a_r9_full_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(buf_full));

  a_r9_switch0: assert property (@(posedge clk) disable iff (!rst_n)
    buf_full[0] |-> cur_buf);

  a_r9_switch1: assert property (@(posedge clk) disable iff (!rst_n)
    buf_full[1] |-> !cur_buf);

  a_r10_ovr_flag: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ovr |=> flags[0]);

  a_r12_hold_ovr: assert property (@(posedge clk) disable iff (!rst_n)
    (flags[0] && !flag_clear[0]) |=> flags[0]);

  a_r12_hold_mbe: assert property (@(posedge clk) disable iff (!rst_n)
    (flags[1] && !flag_clear[1]) |=> flags[1]);

  a_r12_hold_ofl: assert property (@(posedge clk) disable iff (!rst_n)
    (flags[2] && !flag_clear[2]) |=> flags[2]);
endmodule

bind msg_capture msg_capture_chk #(.CW(CW), .TSW(TSW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ev_ovr(ev_ovr), .ev_mbe(ev_mbe), .ev_ofl(ev_ofl),
  .base0_we(base0_we), .base1_we(base1_we), .flag_clear(flag_clear),
  .wf_push(wf_push), .buf_full(buf_full), .flags(flags), .cur_buf(cur_buf),
  .done_cnt0(done_cnt0), .done_cnt1(done_cnt1), .ts_now(ts_now)
);

// File: tb/tb_msg_capture.sv
module tb_msg_capture;
  localparam logic [1:0] OP_IDLE = 2'd0, OP_START = 2'd1, OP_STOP = 2'd2, OP_SMP = 2'd3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] base0_wdata = '0, base1_wdata = '0;
  logic        base0_we = 1'b0, base1_we = 1'b0;
  logic [7:0]  rec_words = 8'd4;
  logic [7:0]  rec_count = 8'd2;
  logic        ts_insert = 1'b0, ovr_enable = 1'b0;
  logic        evt_start = 1'b0, evt_stop = 1'b0, smp_valid = 1'b0;
  logic [31:0] smp_data = '0;
  logic [1:0]  full_ack = '0;
  logic [2:0]  flag_clear = '0;
  logic        wf_full = 1'b0;
  logic        wf_push;
  logic [31:0] wf_addr, wf_data;
  logic [1:0]  buf_full;
  logic [15:0] done_cnt0, done_cnt1;
  logic [2:0]  flags;
  logic        cur_buf;
  logic [31:0] ts_now;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;  // 125 MHz

  msg_capture dut (
    .clk(clk), .rst_n(rst_n),
    .base0_wdata(base0_wdata), .base0_we(base0_we),
    .base1_wdata(base1_wdata), .base1_we(base1_we),
    .rec_words(rec_words), .rec_count(rec_count),
    .ts_insert(ts_insert), .ovr_enable(ovr_enable),
    .evt_start(evt_start), .evt_stop(evt_stop), .smp_valid(smp_valid),
    .smp_data(smp_data), .full_ack(full_ack), .flag_clear(flag_clear),
    .wf_full(wf_full), .wf_push(wf_push), .wf_addr(wf_addr), .wf_data(wf_data),
    .buf_full(buf_full), .done_cnt0(done_cnt0), .done_cnt1(done_cnt1),
    .flags(flags), .cur_buf(cur_buf), .ts_now(ts_now)
  );

  // expected word address: base + 4*(slot*size + offset)
  function automatic logic [31:0] exp_addr(input logic [31:0] base, input int slot, input int off);
    return base + 32'((slot * int'(rec_words) + off) * 4);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // one clock with the given stream op; outputs readable on return
  task automatic cyc(input logic [1:0] op, input logic [31:0] d);
    @(negedge clk);
    evt_start = (op == OP_START);
    evt_stop  = (op == OP_STOP);
    smp_valid = (op == OP_SMP);
    smp_data  = d;
    @(posedge clk); #1;
    evt_start = 1'b0; evt_stop = 1'b0; smp_valid = 1'b0;
    full_ack = '0; flag_clear = '0; base0_we = 1'b0; base1_we = 1'b0;
  endtask

  typedef struct packed {
    logic [1:0]  op;
    logic [31:0] data;
    logic        push;
    logic        full0;
    logic [31:0] addr;
  } vec_t;

  // base0=0x1000, base1=0x2000, 4-word slots, 2 slots per buffer
  localparam vec_t VEC [0:10] = '{
    '{OP_START, 32'h0,    1'b0, 1'b0, 32'h0},
    '{OP_SMP,   32'hA001, 1'b1, 1'b0, 32'h1000},
    '{OP_SMP,   32'hA002, 1'b1, 1'b0, 32'h1004},
    '{OP_STOP,  32'h0,    1'b0, 1'b0, 32'h0},
    '{OP_START, 32'h0,    1'b0, 1'b0, 32'h0},
    '{OP_SMP,   32'hB001, 1'b1, 1'b0, 32'h1010},
    '{OP_STOP,  32'h0,    1'b0, 1'b1, 32'h0},
    '{OP_START, 32'h0,    1'b0, 1'b0, 32'h0},
    '{OP_SMP,   32'hC001, 1'b1, 1'b0, 32'h2000},
    '{OP_SMP,   32'hC002, 1'b1, 1'b0, 32'h2004},
    '{OP_STOP,  32'h0,    1'b0, 1'b0, 32'h0}
  };

  task automatic finish_run;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [31:0] tsv, t0;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1 push", 32'(wf_push), 0);
    chk("R1 flags", 32'(flags), 0);
    chk("R1 cnt", 32'({done_cnt0, done_cnt1}), 0);
    chk("R1 cur/full", 32'({cur_buf, buf_full}), 0);

    @(negedge clk);
    rst_n = 1'b1;
    base0_wdata = 32'h1000; base0_we = 1'b1;
    base1_wdata = 32'h2000; base1_we = 1'b1;
    cyc(OP_IDLE, 0);

    // R2 / R9 table walk
    for (int i = 0; i <= 10; i++) begin
      cyc(VEC[i].op, VEC[i].data);
      chk($sformatf("R2 push v%0d", i), 32'(wf_push), 32'(VEC[i].push));
      if (VEC[i].push) begin
        chk($sformatf("R2 addr v%0d", i), wf_addr, VEC[i].addr);
        chk($sformatf("R2 data v%0d", i), wf_data, VEC[i].data);
      end
      chk($sformatf("R9 full0 v%0d", i), 32'(buf_full[0]), 32'(VEC[i].full0));
    end
    chk("R9 cur after switch", 32'(cur_buf), 1);
    chk("R7 cnt0", 32'(done_cnt0), 2);
    chk("R7 cnt1", 32'(done_cnt1), 1);

    // R11 ack buffer 0
    @(negedge clk); full_ack = 2'b01;
    cyc(OP_IDLE, 0);

    // R5 truncation in buffer 1 slot 1
    cyc(OP_START, 0);
    for (int k = 0; k < 4; k++) begin
      cyc(OP_SMP, 32'hD000 + 32'(k));
      chk("R5 fit push", 32'(wf_push), 1);
      chk("R5 fit addr", wf_addr, exp_addr(32'h2000, 1, k));
    end
    cyc(OP_SMP, 32'hDEAD);
    chk("R5 drop push", 32'(wf_push), 0);
    chk("R5 ofl flag", 32'(flags), 3'b100);
    cyc(OP_STOP, 0);
    chk("R9 full1 pulse", 32'(buf_full), 2'b10);
    chk("R9 cur back to 0", 32'(cur_buf), 0);
    chk("R7 cnt1", 32'(done_cnt1), 2);
    cyc(OP_IDLE, 0);
    chk("R9 pulse one cycle", 32'(buf_full), 0);

    // R12 clear overflow only
    @(negedge clk); flag_clear = 3'b100;
    cyc(OP_IDLE, 0);
    chk("R12 ofl cleared", 32'(flags), 0);

    // R3 timestamp in buffer 0 slot 0
    @(negedge clk); full_ack = 2'b10;
    cyc(OP_IDLE, 0);
    ts_insert = 1'b1;
    @(negedge clk);
    tsv = ts_now;
    evt_start = 1'b1;
    @(posedge clk); #1;
    evt_start = 1'b0;
    chk("R3 ts push", 32'(wf_push), 1);
    chk("R3 ts addr", wf_addr, 32'h1000);
    chk("R3 ts data", wf_data, tsv);
    cyc(OP_SMP, 32'h00AB);
    chk("R3 sample after ts", wf_addr, 32'h1004);
    cyc(OP_STOP, 0);
    ts_insert = 1'b0;
    chk("R7 cnt0", 32'(done_cnt0), 3);

    // R4 timer rate
    t0 = ts_now;
    repeat (8) @(posedge clk);
    #1;
    chk("R4 ts +1 per 8", ts_now, t0 + 1);

    // R6 bandwidth error in buffer 0 slot 1
    cyc(OP_START, 0);
    wf_full = 1'b1;
    cyc(OP_SMP, 32'hE001);
    chk("R6 lost push", 32'(wf_push), 0);
    chk("R6 mbe flag", 32'(flags), 3'b010);
    wf_full = 1'b0;
    cyc(OP_SMP, 32'hE002);
    chk("R6 next addr kept", wf_addr, exp_addr(32'h1000, 1, 1));
    chk("R6 next data", wf_data, 32'hE002);
    cyc(OP_STOP, 0);
    chk("R9 full0 pulse", 32'(buf_full), 2'b01);
    chk("R7 cnt0", 32'(done_cnt0), 4);

    // R8 base rewrite clears only that counter
    @(negedge clk); base0_wdata = 32'h1000; base0_we = 1'b1;
    cyc(OP_IDLE, 0);
    chk("R8 cnt0 cleared", 32'(done_cnt0), 0);
    chk("R8 cnt1 kept", 32'(done_cnt1), 2);

    // R10 overrun: fill buffer 1, then start into unacked buffer 0
    ovr_enable = 1'b1;
    cyc(OP_START, 0); cyc(OP_STOP, 0);
    cyc(OP_START, 0); cyc(OP_STOP, 0);
    chk("R9 cur to 0", 32'(cur_buf), 0);
    cyc(OP_START, 0);
    chk("R10 ovr flag", 32'(flags), 3'b011);
    chk("R10 no push", 32'(wf_push), 0);
    cyc(OP_SMP, 32'hF00D);
    chk("R10 sample ignored", 32'(wf_push), 0);
    cyc(OP_STOP, 0);
    chk("R10 stop ignored", 32'(done_cnt0), 0);
    cyc(OP_START, 0);
    cyc(OP_SMP, 32'hF00E);
    chk("R10 still stalled", 32'(wf_push), 0);

    // R11 ack other buffer resumes there
    @(negedge clk); full_ack = 2'b10;
    cyc(OP_IDLE, 0);
    chk("R11 resume buffer", 32'(cur_buf), 1);
    cyc(OP_START, 0);
    cyc(OP_SMP, 32'h0055);
    chk("R11 push", 32'(wf_push), 1);
    chk("R11 addr", wf_addr, 32'h2000);
    cyc(OP_STOP, 0);
    chk("R7 cnt1 after resume", 32'(done_cnt1), 5);

    // R12 independent clears
    @(negedge clk); flag_clear = 3'b010;
    cyc(OP_IDLE, 0);
    chk("R12 mbe cleared ovr kept", 32'(flags), 3'b001);
    cyc(OP_IDLE, 0);
    chk("R12 ovr sticky", 32'(flags), 3'b001);
    @(negedge clk); flag_clear = 3'b001;
    cyc(OP_IDLE, 0);
    chk("R12 ovr cleared", 32'(flags), 0);

    finish_run();
  end
endmodule